// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Gate

This block sits between a host and an external static RAM that keeps its contents on a backup cell. It passes the host's active-low chip enable through to the RAM only while the main supply is healthy, so that no stray write can corrupt the stored data while the supply collapses or while it is coming back. Supply health arrives as a digital power-fail indication from an external comparator. The raw indication blocks the RAM at once, with no clock involved. A synchronised copy of it drives a recovery lockout that keeps the RAM blocked for a parameterised number of clock cycles once the supply is good again.

The block also produces a power-fail output for the host, which is held low whenever the system runs from the backup cell. It produces a low-battery flag from a digitised battery-voltage code. The flag uses two code thresholds, standing for 2.3 V and 2.5 V, so that a noisy reading near one trip point does not make it toggle.

Top module: `sram_ce_gate`

## Requirements
- R1: While `pwr_fail` is 1, `ce_out_n` is 1 regardless of `ce_in_n`, with no clock edge needed.
- R2: When `pwr_fail` falls and stays 0, `ce_out_n` stays 1 through the first 1+RECOVERY_CYCLES rising edges after the fall. From the (2+RECOVERY_CYCLES)th edge on, it follows `ce_in_n`.
- R3: If `pwr_fail` is reasserted for two or more edges during the lockout, the full recovery count restarts from its next fall.
- R4: While `batt_mode` is 1, `pfo` is 0.
- R5: While `batt_mode` is 0, `pfo` is the inverse of `pwr_fail` delayed by two rising edges (two-flop synchroniser).
- R6: On a rising edge where `batt_code` < BATT_LO_CODE (2.3 V), `batt_low` becomes 1.
- R7: On a rising edge where `batt_code` > BATT_HI_CODE (2.5 V), `batt_low` becomes 0.
- R8: On a rising edge where BATT_LO_CODE <= `batt_code` <= BATT_HI_CODE, `batt_low` keeps its value.
- R9: Outside power-fail and lockout, `ce_out_n` equals `ce_in_n` combinationally.
- R10: Reset (`rst_n` = 0) sets `batt_low` to 0 and enters the lockout. `ce_out_n` is 1 through the first RECOVERY_CYCLES-1 rising edges after reset is released, and follows `ce_in_n` from the RECOVERY_CYCLES-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in_n | input | 1 | Host chip enable, active low |
| pwr_fail | input | 1 | Main supply below fail threshold, asynchronous |
| batt_mode | input | 1 | System running from backup cell |
| batt_code | input | BATT_W | Digitised battery voltage |
| ce_out_n | output | 1 | Gated chip enable to the RAM, active low |
| pfo | output | 1 | Power-fail output, low on failure or in battery mode |
| batt_low | output | 1 | Low-battery flag with hysteresis |

## Verification
On every cycle, the assertions check four things: the asynchronous blocking under `pwr_fail`, the blocking while the lockout timer runs, the low `pfo` in battery mode, and the direction of each battery-flag update, including the hold inside the band. Only the directed scenarios can show the exact edge count at which the lockout opens after reset and after a power return. The same holds for the restart of the count when the supply dips again during lockout, and for the two-edge latency of `pfo`.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;
   // Lockout state seen by the gate: open passes the host enable through
   typedef enum logic [1:0] {
      GATE_OPEN    = 2'd0,
      GATE_FAILED  = 2'd1,
      GATE_RECOVER = 2'd2
   } gate_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   initial begin
      if (STAGES < 2) $error("pf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/recovery_lock.sv
module recovery_lock
   import sram_gate_pkg::*;
#(
   parameter int unsigned RECOVERY_CYCLES = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fail_sync,
   output gate_state_e state,
   output logic        open
);
   localparam int unsigned CW = cnt_width(RECOVERY_CYCLES);
   localparam logic [CW-1:0] RELOAD = CW'(RECOVERY_CYCLES);

   initial begin
      if (RECOVERY_CYCLES < 1) $error("recovery_lock: RECOVERY_CYCLES must be at least 1");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= RELOAD;
      else if (fail_sync)      remain <= RELOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   always_comb begin
      if (fail_sync)          state = GATE_FAILED;
      else if (remain != '0)  state = GATE_RECOVER;
      else                    state = GATE_OPEN;
   end

   assign open = (state == GATE_OPEN);

   // R3
   reload_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_sync |=> (remain == RELOAD));

   // R2
   count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= RELOAD);

   // R2
   count_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fail_sync && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/batt_flag.sv
module batt_flag #(
   parameter int unsigned BATT_W  = 8,
   parameter int unsigned LO_CODE = 115,
   parameter int unsigned HI_CODE = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BATT_W-1:0] code,
   output logic              low
);
   localparam logic [BATT_W-1:0] LO = BATT_W'(LO_CODE);
   localparam logic [BATT_W-1:0] HI = BATT_W'(HI_CODE);

   initial begin
      if (HI_CODE <= LO_CODE)     $error("batt_flag: HI_CODE must exceed LO_CODE");
      if (HI_CODE >= (1 << BATT_W)) $error("batt_flag: HI_CODE does not fit BATT_W");
   end

   logic below, above;
   assign below = (code < LO);
   assign above = (code > HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low <= 1'b0;
      else if (below) low <= 1'b1;
      else if (above) low <= 1'b0;
   end
endmodule

// File: rtl/sram_ce_gate.sv
module sram_ce_gate
   import sram_gate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned RECOVERY_CYCLES = 1024,
   parameter int unsigned BATT_W          = 8,
   parameter int unsigned BATT_LO_CODE    = 115,
   parameter int unsigned BATT_HI_CODE    = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_in_n,
   input  logic              pwr_fail,
   input  logic              batt_mode,
   input  logic [BATT_W-1:0] batt_code,
   output logic              ce_out_n,
   output logic              pfo,
   output logic              batt_low
);
   logic        fail_sync;
   logic        lock_open;
   gate_state_e lock_state;

   pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pwr_fail),
      .sync_out (fail_sync)
   );

   recovery_lock #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .fail_sync (fail_sync),
      .state     (lock_state),
      .open      (lock_open)
   );

   batt_flag #(.BATT_W(BATT_W), .LO_CODE(BATT_LO_CODE), .HI_CODE(BATT_HI_CODE)) u_batt (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (batt_code),
      .low   (batt_low)
   );

   // Raw input blocks without waiting for the synchroniser
   assign ce_out_n = ce_in_n | pwr_fail | ~lock_open;
   assign pfo      = ~batt_mode & ~fail_sync;

   // R1
   async_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |-> ce_out_n);

   // R2
   lockout_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_state != GATE_OPEN) |-> ce_out_n);

   // R4
   batt_pfo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      batt_mode |-> !pfo);

   // R6
   batt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (batt_code < BATT_W'(BATT_LO_CODE)) |=> batt_low);

   // R7
   batt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (batt_code > BATT_W'(BATT_HI_CODE)) |=> !batt_low);

   // R8
   batt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (batt_code >= BATT_W'(BATT_LO_CODE) && batt_code <= BATT_W'(BATT_HI_CODE))
      |=> $stable(batt_low));
endmodule

// File: tb/sim_sram_ce_gate.sv
`timescale 1ns/100ps
module sim_sram_ce_gate;
   localparam int unsigned REC = 16;
   localparam int unsigned LO  = 115;
   localparam int unsigned HI  = 125;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_in_n = 1'b1;
   logic       pwr_fail = 1'b0;
   logic       batt_mode = 1'b0;
   logic [7:0] batt_code = 8'd128;
   logic       ce_out_n, pfo, batt_low;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   sram_ce_gate #(.RECOVERY_CYCLES(REC), .BATT_W(8),
                  .BATT_LO_CODE(LO), .BATT_HI_CODE(HI)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .pwr_fail(pwr_fail),
      .batt_mode(batt_mode), .batt_code(batt_code),
      .ce_out_n(ce_out_n), .pfo(pfo), .batt_low(batt_low));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // advance one rising edge, return 1 ns later
   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; ce_in_n = 1'b0; pwr_fail = 1'b0; batt_mode = 1'b0;
      tick(2);
      check("R10 reset batt_low", batt_low, 1'b0);
      check("R10 reset ce blocked", ce_out_n, 1'b1);
      rst_n = 1'b1;
      tick(REC - 1);
      check("R10 still locked before count", ce_out_n, 1'b1);
      tick(1);
      check("R10 open after count", ce_out_n, 1'b0);
      check("R5 pfo high with good supply", pfo, 1'b1);
   endtask

   task automatic t_follow;
      ce_in_n = 1'b1; #0.5;
      check("R9 follow high", ce_out_n, 1'b1);
      ce_in_n = 1'b0; #0.5;
      check("R9 follow low", ce_out_n, 1'b0);
      tick(1);
   endtask

   task automatic t_recovery;
      ce_in_n = 1'b0;
      pwr_fail = 1'b1; #0.5;
      check("R1 immediate block", ce_out_n, 1'b1);
      tick(1);
      check("R5 pfo after one edge", pfo, 1'b1);
      tick(1);
      check("R5 pfo after two edges", pfo, 1'b0);
      tick(3);
      pwr_fail = 1'b0;
      tick(1 + REC);
      check("R2 still locked at 1+REC", ce_out_n, 1'b1);
      tick(1);
      check("R2 open at 2+REC", ce_out_n, 1'b0);
   endtask

   task automatic t_restart;
      ce_in_n = 1'b0;
      pwr_fail = 1'b1; tick(4);
      pwr_fail = 1'b0; tick(6);
      pwr_fail = 1'b1; tick(3);
      check("R3 blocked during dip", ce_out_n, 1'b1);
      pwr_fail = 1'b0;
      tick(1 + REC);
      check("R3 restarted count still locked", ce_out_n, 1'b1);
      tick(1);
      check("R3 open after restarted count", ce_out_n, 1'b0);
   endtask

   task automatic t_pfo_batt;
      batt_mode = 1'b1; #0.5;
      check("R4 pfo low in battery mode", pfo, 1'b0);
      batt_mode = 1'b0; #0.5;
      check("R5 pfo high after battery mode", pfo, 1'b1);
      tick(1);
   endtask

   task automatic t_battery;
      batt_code = 8'(HI + 1); tick(1);
      check("R7 clear above high", batt_low, 1'b0);
      batt_code = 8'(LO); tick(1);
      check("R8 hold at low edge", batt_low, 1'b0);
      batt_code = 8'(LO - 1); tick(1);
      check("R6 set below low", batt_low, 1'b1);
      batt_code = 8'(HI); tick(1);
      check("R8 hold at high edge", batt_low, 1'b1);
      batt_code = 8'(LO + 5); tick(1);
      check("R8 hold mid band", batt_low, 1'b1);
      batt_code = 8'(HI + 1); tick(1);
      check("R7 clear again", batt_low, 1'b0);
      batt_code = 8'd0; tick(1);
      check("R6 set at zero code", batt_low, 1'b1);
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_follow();
      t_recovery();
      t_restart();
      t_pfo_batt();
      t_battery();
      finish_run();
   end
endmodule